// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog with one control and status word on a simple synchronous bus. While it is enabled, an up counter advances on every clock of the selected slow timebase. When the counter reaches the interval picked by a 3-bit select field, a time-out flag is raised. The flag can drive an interrupt and, when the timebase is a low-speed source, a wake-up trigger. The time-out starts a second, fixed window of 1024 clocks. If software has not pulsed the reload input by the end of that window and reset requests are enabled, the block issues a one-cycle system reset request. It also records the event in a flag that survives the reset it caused.

The enable, interrupt enable, wake enable, reset enable and wake flag fields change only while an external unlock input is high. The time-out, wake and reset flags are cleared by writing 1 to them. Unless a 3-bit configuration input is all ones, the watchdog is held on and cannot be switched off by software.

Register word, read and write (a single register, no address): bit 0 reserved (reads 0), bit 1 reset enable, bit 2 reset flag, bit 3 time-out flag, bit 4 wake enable, bit 5 wake flag, bit 6 interrupt enable, bit 7 enable, bits 10:8 interval select, upper bits read 0.

Top module: `wdog_timer`

## Requirements
- R1: Clearing the enable bit stops the watchdog and returns its up count to zero, so after a re-enable a full interval elapses before the time-out flag sets.
- R2: While cfgForce differs from 3'b111, bit 7 reads 1, a software write of 0 to it has no effect, and the counter keeps running.
- R3: With select value s in bits 10:8, the time-out flag (bit 3) reads 1 exactly 2^(4+2s) clocks after the write edge that enables the watchdog or after the reload edge, and reads 0 one clock earlier.
- R4: irqOut is high exactly when bit 3 and bit 6 are both 1.
- R5: wakeOut is high exactly when bit 3, bit 6 and bit 4 are 1 and clkSrcLow is 1; the wake flag (bit 5) reads 1 from the clock after wakeOut rises.
- R6: Writing 1 to bit 3, to bit 2, or (with unlock high) to bit 5 clears that flag; writing 0 to a flag leaves it unchanged, and a bit 5 clear without unlock is ignored.
- R7: With bit 1 set, rstReqOut pulses high for exactly one clock, 1024 clocks after the time-out flag sets, and bit 2 sets on the same edge; with bit 1 clear no request is issued.
- R8: With unlock low, writes leave bits 1, 4, 5, 6 and 7 unchanged while bits 10:8 still take the written value; bit 0 always reads 0.
- R9: A pulse on kick restarts both the interval count and the 1024-clock window, so a reload during the window postpones the reset request to a full interval plus 1024 clocks after the reload.
- R10: Bit 2 keeps its value through rstN, which clears every other field, and is cleared by porN.
- R11: After porN, the register reads 0 (with cfgForce at 3'b111) and irqOut, wakeOut and rstReqOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected watchdog timebase clock |
| rstN | input | 1 | Asynchronous active-low system reset; keeps the reset flag |
| porN | input | 1 | Asynchronous active-low power-on reset; clears everything |
| cfgForce | input | 3 | Configuration code; any value other than 3'b111 holds the watchdog on |
| unlock | input | 1 | High allows writes to the protected fields |
| clkSrcLow | input | 1 | High when the timebase is a low-speed source; gates wake-up |
| regWr | input | 1 | Register write strobe, one cycle |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, combinational |
| kick | input | 1 | Reload strobe; restarts interval and delay counts |
| irqOut | output | 1 | Time-out interrupt |
| wakeOut | output | 1 | Wake-up trigger |
| rstReqOut | output | 1 | One-clock system reset request |

## Verification
Register writes take effect on the clock edge that samples them, so the read word and irqOut and wakeOut show the new value half a clock later. The time-out flag lands exactly 2^(4+2s) edges after the enabling write or the reload, and the wake flag one edge after that. The reset request and reset flag land 1024 edges after the time-out flag, and the request drops again on the following edge. The bench drives and samples on falling edges and counts edges from the one that took the stimulus. It checks the value one edge before each due edge, on the due edge itself, and, for the reset pulse, on the edge after, so an early, late or stretched result is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int SEL_W     = 3;

  // Field positions of the register word
  localparam int BIT_RSTEN = 1;
  localparam int BIT_RSTF  = 2;
  localparam int BIT_TOF   = 3;
  localparam int BIT_WKEN  = 4;
  localparam int BIT_WKF   = 5;
  localparam int BIT_IE    = 6;
  localparam int BIT_EN    = 7;
  localparam int SEL_LO    = 8;
  localparam int REG_TOP   = SEL_LO + SEL_W;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic             run;
    logic             restart;
    logic [SEL_W-1:0] sel;
  } ctl_strb_t;

  // Events from the datapath to the control
  typedef struct packed {
    logic timeoutHit;
    logic delayDone;
  } dp_evt_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int BASE_EXP  = 4,
  parameter int DELAY_CYC = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctl_strb_t ctl,
  output dp_evt_t   evt
);

  localparam int NUM_SEL = 1 << SEL_W;
  localparam int CNT_W   = BASE_EXP + 2 * (NUM_SEL - 1);
  localparam int DLY_W   = $clog2(DELAY_CYC);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DELAY_CYC - 1);

  typedef enum logic [1:0] {PH_COUNT, PH_DELAY, PH_DONE} phase_e;

  logic [CNT_W-1:0] cntQ;
  logic [DLY_W-1:0] dlyQ;
  phase_e           phaseQ;

  // Last count value of each selectable interval: 2^(BASE_EXP+2*sel)-1
  logic [CNT_W-1:0] lastTab [NUM_SEL];
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lastTab[g] = {CNT_W{1'b1}} >> (CNT_W - BASE_EXP - 2 * g);
  end

  logic live, cntHit, dlyHit;
  assign live   = ctl.run && !ctl.restart;
  assign cntHit = (phaseQ == PH_COUNT) && (cntQ >= lastTab[ctl.sel]);
  assign dlyHit = (phaseQ == PH_DELAY) && (dlyQ == DLY_LAST);

  assign evt.timeoutHit = live && cntHit;
  assign evt.delayDone  = live && dlyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      dlyQ   <= '0;
      phaseQ <= PH_COUNT;
    end else if (!live) begin
      cntQ   <= '0;
      dlyQ   <= '0;
      phaseQ <= PH_COUNT;
    end else begin
      unique case (phaseQ)
        PH_COUNT: begin
          if (cntHit) begin
            phaseQ <= PH_DELAY;
            dlyQ   <= '0;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        PH_DELAY: begin
          if (dlyHit) phaseQ <= PH_DONE;
          else        dlyQ   <= dlyQ + 1'b1;
        end
        default: phaseQ <= PH_DONE;
      endcase
    end
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              porN,
  input  logic [2:0]        cfgForce,
  input  logic              unlock,
  input  logic              clkSrcLow,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              kick,
  input  dp_evt_t           evt,
  output ctl_strb_t         ctl,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut,
  output logic              wakeOut,
  output logic              rstReqOut
);

  localparam logic [2:0] CFG_FREE = 3'b111;

  logic             enQ, ieQ, wkenQ, rstenQ;
  logic             tofQ, wkfQ, rstfQ, wakeSeenQ;
  logic [SEL_W-1:0] selQ;
  logic             forcedOn, effEn, protWr, rstReqSet, wkfSet;

  logic unusedWrBits;
  assign unusedWrBits = ^{regWdata[DATA_W-1:REG_TOP], regWdata[0]};

  assign forcedOn  = (cfgForce != CFG_FREE);
  assign effEn     = enQ | forcedOn;
  assign protWr    = regWr & unlock;
  assign rstReqSet = evt.delayDone & rstenQ;

  assign irqOut  = tofQ & ieQ;
  assign wakeOut = irqOut & wkenQ & clkSrcLow;
  assign wkfSet  = wakeOut & !wakeSeenQ;

  assign ctl.run     = effEn;
  assign ctl.restart = kick;
  assign ctl.sel     = selQ;

  // Protected enables and the unprotected interval select
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      enQ    <= 1'b0;
      ieQ    <= 1'b0;
      wkenQ  <= 1'b0;
      rstenQ <= 1'b0;
      selQ   <= '0;
    end else begin
      if (regWr) selQ <= regWdata[REG_TOP-1:SEL_LO];
      if (protWr) begin
        enQ    <= regWdata[BIT_EN];
        ieQ    <= regWdata[BIT_IE];
        wkenQ  <= regWdata[BIT_WKEN];
        rstenQ <= regWdata[BIT_RSTEN];
      end
    end
  end

  // Sticky flags cleared by a 1 write; a new event wins over a clear
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      tofQ      <= 1'b0;
      wkfQ      <= 1'b0;
      wakeSeenQ <= 1'b0;
      rstReqOut <= 1'b0;
    end else begin
      wakeSeenQ <= wakeOut;
      rstReqOut <= rstReqSet;
      if (evt.timeoutHit)                tofQ <= 1'b1;
      else if (regWr && regWdata[BIT_TOF]) tofQ <= 1'b0;
      if (wkfSet)                         wkfQ <= 1'b1;
      else if (protWr && regWdata[BIT_WKF]) wkfQ <= 1'b0;
    end
  end

  // Reset flag survives the system reset it triggers
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                            rstfQ <= 1'b0;
    else if (rstReqSet)                   rstfQ <= 1'b1;
    else if (regWr && regWdata[BIT_RSTF]) rstfQ <= 1'b0;
  end

  always_comb begin
    regRdata                        = '0;
    regRdata[BIT_RSTEN]             = rstenQ;
    regRdata[BIT_RSTF]              = rstfQ;
    regRdata[BIT_TOF]               = tofQ;
    regRdata[BIT_WKEN]              = wkenQ;
    regRdata[BIT_WKF]               = wkfQ;
    regRdata[BIT_IE]                = ieQ;
    regRdata[BIT_EN]                = effEn;
    regRdata[REG_TOP-1:SEL_LO]      = selQ;
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BASE_EXP  = 4,
  parameter int DELAY_CYC = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic [2:0]        cfgForce,
  input  logic              unlock,
  input  logic              clkSrcLow,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              kick,
  output logic              irqOut,
  output logic              wakeOut,
  output logic              rstReqOut
);

  localparam int CNT_W = BASE_EXP + 2 * ((1 << SEL_W) - 1);

  logic      sysRstN;
  ctl_strb_t ctlStrb;
  dp_evt_t   dpEvt;

  assign sysRstN = rstN & porN;

  wdog_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .porN      (porN),
    .cfgForce  (cfgForce),
    .unlock    (unlock),
    .clkSrcLow (clkSrcLow),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .kick      (kick),
    .evt       (dpEvt),
    .ctl       (ctlStrb),
    .regRdata  (regRdata),
    .irqOut    (irqOut),
    .wakeOut   (wakeOut),
    .rstReqOut (rstReqOut)
  );

  wdog_datapath #(.BASE_EXP(BASE_EXP), .DELAY_CYC(DELAY_CYC)) u_dp (
    .clk  (clk),
    .rstN (sysRstN),
    .ctl  (ctlStrb),
    .evt  (dpEvt)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             porN,
  input logic [2:0]       cfgForce,
  input logic             unlock,
  input logic             clkSrcLow,
  input logic [7:1]       stBits,
  input logic             irqOut,
  input logic             wakeOut,
  input logic             rstReqOut,
  input logic             runStrb,
  input logic [CNT_W-1:0] dpCnt
);

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !runStrb |=> (dpCnt == '0)); // R1

  AST_FORCED_EN_READS_ONE: assert property (@(posedge clk) disable iff (!rstN || !porN)
    (cfgForce != 3'b111) |-> stBits[7]); // R2

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN || !porN)
    irqOut |-> (stBits[3] && stBits[6])); // R4

  AST_WAKE_NEEDS_SLOW_CLK: assert property (@(posedge clk) disable iff (!rstN || !porN)
    wakeOut |-> (clkSrcLow && irqOut && stBits[4])); // R5

  AST_RSTREQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN || !porN)
    rstReqOut |-> stBits[2]); // R7

  AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN || !porN)
    rstReqOut |=> !rstReqOut); // R7

  AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rstN || !porN)
    !unlock |=> $stable({stBits[6], stBits[4], stBits[1]})); // R8

endmodule

bind wdog_timer wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .porN      (porN),
  .cfgForce  (cfgForce),
  .unlock    (unlock),
  .clkSrcLow (clkSrcLow),
  .stBits    (regRdata[7:1]),
  .irqOut    (irqOut),
  .wakeOut   (wakeOut),
  .rstReqOut (rstReqOut),
  .runStrb   (ctlStrb.run),
  .dpCnt     (u_dp.cntQ)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;

  localparam int DLY = 1024;

  logic        clk = 1'b0;
  logic        rstN, porN, unlock, clkSrcLow, regWr, kick;
  logic [2:0]  cfgForce;
  logic [31:0] regWdata, regRdata;
  logic        irqOut, wakeOut, rstReqOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .cfgForce(cfgForce), .unlock(unlock),
    .clkSrcLow(clkSrcLow), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .kick(kick), .irqOut(irqOut), .wakeOut(wakeOut), .rstReqOut(rstReqOut)
  );

  function automatic int limitOf(input int s);
    return 1 << (4 + 2 * s);
  endfunction

  function automatic logic [31:0] mk(input int s, input bit en, input bit ie,
                                     input bit wken, input bit rsten, input bit clrFlags);
    logic [31:0] w;
    w = 32'(s) << 8;
    w[7] = en; w[6] = ie; w[4] = wken; w[1] = rsten;
    if (clrFlags) w = w | 32'h2C;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input bit unl, input bit kk);
    @(negedge clk);
    regWr = 1'b1; regWdata = d; unlock = unl; kick = kk;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0; unlock = 1'b0; kick = 1'b0;
  endtask

  task automatic doKick();
    doWrite(32'h0, 1'b0, 1'b1);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic porPulse();
    @(negedge clk); porN = 1'b0;
    waitN(2); porN = 1'b1;
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish();
  end

  initial begin
    int unsigned seed;
    int hits;
    rstN = 1'b0; porN = 1'b0; unlock = 1'b0; clkSrcLow = 1'b0;
    regWr = 1'b0; kick = 1'b0; regWdata = '0; cfgForce = 3'b111;
    waitN(3);
    rstN = 1'b1; porN = 1'b1;
    waitN(1);

    // R11 reset state
    chk("R11 reg", regRdata, 32'h0);
    chk("R11 outs", {29'd0, irqOut, wakeOut, rstReqOut}, 32'h0);

    // R8 locked write: only the select field lands, bit 0 stays 0
    doWrite(32'h7FF, 1'b0, 1'b0);
    chk("R8 locked", regRdata, 32'h700);
    doWrite(32'h001, 1'b1, 1'b0);
    chk("R8 reserved bit0", regRdata, 32'h0);

    // R3/R4/R5 randomised runs
    seed = $urandom(32'd7321);
    for (int it = 0; it < 10; it++) begin
      int s; bit ie, wk, lo; logic [31:0] w;
      s  = int'($urandom % 4);
      ie = 1'($urandom); wk = 1'($urandom); lo = 1'($urandom);
      clkSrcLow = lo;
      w = mk(s, 1'b1, ie, wk, 1'b0, 1'b0);
      doWrite(w, 1'b1, 1'b0);
      chk("R8 unlocked write", regRdata, w);
      waitN(limitOf(s) - 1);
      chk("R3 not yet", 32'(regRdata[3]), 32'h0);
      waitN(1);
      chk("R3 flag set", 32'(regRdata[3]), 32'h1);
      chk("R4 irq", 32'(irqOut), 32'(ie));
      chk("R5 wake", 32'(wakeOut), 32'(ie & wk & lo));
      waitN(1);
      chk("R5 wake flag", 32'(regRdata[5]), 32'(ie & wk & lo));
      doWrite(mk(s, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1), 1'b1, 1'b0);
      chk("R6 cleared", regRdata, 32'(s) << 8);
    end
    clkSrcLow = 1'b0;

    // R1 disable restarts the count
    doWrite(mk(0, 1, 0, 0, 0, 0), 1'b1, 1'b0);
    waitN(10);
    doWrite(32'h0, 1'b1, 1'b0);
    waitN(5);
    doWrite(mk(0, 1, 0, 0, 0, 0), 1'b1, 1'b0);
    waitN(15);
    chk("R1 no early flag", 32'(regRdata[3]), 32'h0);
    waitN(1);
    chk("R1 full interval", 32'(regRdata[3]), 32'h1);
    doWrite(mk(0, 0, 0, 0, 0, 1), 1'b1, 1'b0);

    // R6 flag clearing rules
    clkSrcLow = 1'b1;
    doWrite(mk(0, 1, 1, 1, 0, 0), 1'b1, 1'b0);
    waitN(17);
    chk("R6 setup", regRdata & 32'h28, 32'h28);
    doWrite(32'h020, 1'b0, 1'b0);
    chk("R6 zero write and locked wkf", regRdata & 32'h28, 32'h28);
    doWrite(32'h008, 1'b0, 1'b0);
    chk("R6 tof w1c", regRdata & 32'h28, 32'h20);
    doWrite(mk(0, 1, 1, 1, 0, 0) | 32'h20, 1'b1, 1'b0);
    chk("R6 wkf w1c", 32'(regRdata[5]), 32'h0);
    doWrite(mk(0, 0, 0, 0, 0, 1), 1'b1, 1'b0);
    clkSrcLow = 1'b0;

    // R2 forced enable
    cfgForce = 3'b000;
    waitN(1);
    chk("R2 reads on", 32'(regRdata[7]), 32'h1);
    doWrite(32'h0, 1'b1, 1'b0);
    chk("R2 write 0 ignored", 32'(regRdata[7]), 32'h1);
    doWrite(32'h008, 1'b1, 1'b1);
    waitN(15);
    chk("R2 running early", 32'(regRdata[3]), 32'h0);
    waitN(1);
    chk("R2 running flag", 32'(regRdata[3]), 32'h1);
    cfgForce = 3'b111;
    doWrite(32'h008, 1'b1, 1'b0);
    chk("R2 released", regRdata, 32'h0);

    // R7 no request without reset enable
    doWrite(mk(0, 1, 0, 0, 0, 0), 1'b1, 1'b0);
    hits = 0;
    for (int c = 0; c < 16 + DLY + 8; c++) begin
      waitN(1);
      if (rstReqOut) hits++;
    end
    chk("R7 disabled no request", 32'(hits), 32'h0);
    doWrite(mk(0, 0, 0, 0, 0, 1), 1'b1, 1'b0);

    // R7 request timing
    doWrite(mk(0, 1, 0, 0, 1, 0), 1'b1, 1'b0);
    waitN(16);
    chk("R7 timeout", 32'(regRdata[3]), 32'h1);
    waitN(DLY - 1);
    chk("R7 not early", 32'(rstReqOut), 32'h0);
    waitN(1);
    chk("R7 request", 32'(rstReqOut), 32'h1);
    chk("R7 flag", 32'(regRdata[2]), 32'h1);
    waitN(1);
    chk("R7 one cycle", 32'(rstReqOut), 32'h0);

    // R10 flag persistence
    @(negedge clk); rstN = 1'b0;
    waitN(2); rstN = 1'b1;
    chk("R10 survives rstN", regRdata, 32'h004);
    porPulse();
    chk("R10 cleared by porN", regRdata, 32'h0);

    // R9 reload during the delay window
    doWrite(mk(0, 1, 0, 0, 1, 0), 1'b1, 1'b0);
    waitN(16 + 500);
    doKick();
    hits = 0;
    for (int c = 0; c < 16 + DLY - 1; c++) begin
      waitN(1);
      if (rstReqOut) hits++;
    end
    chk("R9 postponed", 32'(hits), 32'h0);
    waitN(1);
    chk("R9 late request", 32'(rstReqOut), 32'h1);

    // R6 reset flag clear
    doWrite(32'h00C, 1'b1, 1'b0);
    chk("R6 rstf w1c", regRdata, 32'h0);

    finish();
  end

endmodule